// File: doc/BRIEF.md
# Flash-to-Memory Word Copy Engine

This block copies a run of 32-bit words out of a flash device into system memory without processor help. Software loads a source pointer (flash side) and a destination pointer (memory side), then writes a control word. That word carries a start bit, the run length and an interrupt enable. The engine reads one word from flash, writes it to memory and advances both pointers by one word. It repeats this until the programmed count is used up. It then drops its busy flag, sets a sticky completion flag and, if enabled, raises its interrupt line.

Both sides are plain valid/ready word ports. The flash side has a request channel that carries an address and a response channel that carries data. The memory side is a single write channel. Pin timing of a real flash bus is left to a separate interface block. The run length is written as the word count minus one, so a 14-bit field covers 1 to 16384 words.

Top module: `nordma_top`

## Requirements
- R1: After reset, both pointers and the control word read as zero, irq is 0, and neither fl_req_valid nor mem_wr_valid is asserted.
- R2: While idle, a write at offset 0x08 sets the source pointer and a write at offset 0x0C sets the destination pointer. Each reads back unchanged at the same offset.
- R3: A run programmed with count field C issues exactly C+1 flash reads at source, source+4, and so on. It writes each returned word in the same order to destination, destination+4, and so on.
- R4: In the control word at offset 0x20, bit 31 (start) and bit 30 (busy) read 1 from the cycle after a start write. Both return to 0 on the cycle after the last memory write is accepted.
- R5: After a run of N words, both pointers read back advanced by 4*N.
- R6: Completion sets the status flag (bit 27), and irq equals status AND enable (bit 28). Writing 1 to bit 27 clears status; writing 0 leaves it set.
- R7: A run that completes with enable clear sets status but keeps irq at 0. Setting enable afterwards raises irq.
- R8: While busy, a control write changes only the enable bit and clears status if bit 27 is 1. Pointer writes are dropped, and a second start neither restarts nor lengthens the run.
- R9: A start write with bit 29 (direction) set stores the direction, starts no run and issues no flash request. Only direction clear (flash to memory) moves data.
- R10: The burst field (bits 26:24) and count field (bits 15:2) read back as written, and bits 23:16 and 1:0 read as zero.
- R11: Count field 0 moves exactly one word, and count field 0x3FFF moves 16384 words.
- R12: While ready is low, a pending flash request holds its address and a pending memory write holds its address and data, and the run completes correctly under such stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fl_req_valid | output | 1 | Flash read request valid |
| fl_req_ready | input | 1 | Flash read request accepted |
| fl_req_addr | output | 32 | Flash word address |
| fl_rsp_valid | input | 1 | Flash read data valid |
| fl_rsp_ready | output | 1 | Engine can take read data |
| fl_rsp_data | input | 32 | Flash read data |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 32 | Memory word address |
| mem_wr_data | output | 32 | Memory write data |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions assume that the flash side returns exactly one response for each accepted request. They also assume that a response is never offered before its request has been taken, and that at most one register write arrives per cycle. The bench's flash model raises a response only after it has recorded an accepted request, and it holds that response until it is consumed. Its register tasks issue one single-cycle write at a time. Ready stalls on both channels come from fixed cycle patterns, so held-address and held-data behaviour is exercised without the design seeing an unrequested response.

// File: rtl/nordma_pkg.sv
package nordma_pkg;
  localparam int REG_AW = 6;
  localparam int REG_DW = 32;
  localparam int CNT_W  = 14;
  localparam int BSZ_W  = 3;

  localparam logic [REG_AW-1:0] OFS_SRC = 6'h08;
  localparam logic [REG_AW-1:0] OFS_DST = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_CTL = 6'h20;

  localparam int B_GO    = 31;
  localparam int B_BUSY  = 30;
  localparam int B_DIR   = 29;
  localparam int B_IEN   = 28;
  localparam int B_STAT  = 27;
  localparam int BSZ_LSB = 24;
  localparam int CNT_LSB = 2;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_REQ   = 2'd1,
    MV_WAIT  = 2'd2,
    MV_WRITE = 2'd3
  } mv_state_e;
endpackage

// File: rtl/nordma_regs.sv
module nordma_regs
  import nordma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              run_active,
  input  logic              word_done,
  input  logic              run_done,
  output logic              start,
  output logic [CNT_W-1:0]  start_cnt,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              stat_o,
  output logic              ien_o,
  output logic              irq
);
  // Pointers and control fields
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic              src_en, dst_en;
  logic              dir_q, dir_d, ien_q, ien_d, stat_q, stat_d;
  logic [BSZ_W-1:0]  bsz_q, bsz_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              fld_en, ien_en, stat_en;
  logic              wr_src, wr_dst, wr_ctl;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[23:16], reg_wdata[1:0], reg_wdata[B_BUSY]};

  // Next-state logic
  always_comb begin
    wr_src = reg_wr_en && (reg_addr == OFS_SRC) && !run_active;
    wr_dst = reg_wr_en && (reg_addr == OFS_DST) && !run_active;
    wr_ctl = reg_wr_en && (reg_addr == OFS_CTL);

    // Pointer advance has priority; pointer writes only land when idle.
    src_en = word_done || wr_src;
    dst_en = word_done || wr_dst;
    src_d  = word_done ? src_q + ADDR_W'(STEP) : reg_wdata[ADDR_W-1:0];
    dst_d  = word_done ? dst_q + ADDR_W'(STEP) : reg_wdata[ADDR_W-1:0];

    // Fields frozen during a run
    fld_en = wr_ctl && !run_active;
    dir_d  = reg_wdata[B_DIR];
    bsz_d  = reg_wdata[BSZ_LSB +: BSZ_W];
    cnt_d  = reg_wdata[CNT_LSB +: CNT_W];

    // Enable always writable
    ien_en = wr_ctl;
    ien_d  = reg_wdata[B_IEN];

    // Status: set on completion wins over write-one-to-clear
    stat_en = run_done || (wr_ctl && reg_wdata[B_STAT]);
    stat_d  = run_done;

    start     = fld_en && reg_wdata[B_GO] && !reg_wdata[B_DIR];
    start_cnt = reg_wdata[CNT_LSB +: CNT_W];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      dir_q  <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
      bsz_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (fld_en) begin
        dir_q <= dir_d;
        bsz_q <= bsz_d;
        cnt_q <= cnt_d;
      end
      if (ien_en)  ien_q  <= ien_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SRC: reg_rdata[ADDR_W-1:0] = src_q;
      OFS_DST: reg_rdata[ADDR_W-1:0] = dst_q;
      OFS_CTL: begin
        reg_rdata[B_GO]                = run_active;
        reg_rdata[B_BUSY]              = run_active;
        reg_rdata[B_DIR]               = dir_q;
        reg_rdata[B_IEN]               = ien_q;
        reg_rdata[B_STAT]              = stat_q;
        reg_rdata[BSZ_LSB +: BSZ_W]    = bsz_q;
        reg_rdata[CNT_LSB +: CNT_W]    = cnt_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign src_ptr = src_q;
  assign dst_ptr = dst_q;
  assign stat_o  = stat_q;
  assign ien_o   = ien_q;
  assign irq     = stat_q && ien_q;
endmodule

// File: rtl/nordma_mover.sv
module nordma_mover
  import nordma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic [ADDR_W-1:0] dst_ptr,
  output logic              fl_req_valid,
  input  logic              fl_req_ready,
  output logic [ADDR_W-1:0] fl_req_addr,
  input  logic              fl_rsp_valid,
  output logic              fl_rsp_ready,
  input  logic [DATA_W-1:0] fl_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              word_done,
  output logic              run_done,
  output logic              run_active
);
  mv_state_e         state_q, state_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              left_en;
  logic [DATA_W-1:0] buf_q;
  logic              buf_en;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    left_en   = 1'b0;
    buf_en    = 1'b0;
    word_done = 1'b0;
    run_done  = 1'b0;
    case (state_q)
      MV_IDLE: begin
        if (start) begin
          state_d = MV_REQ;
          left_d  = start_cnt;
          left_en = 1'b1;
        end
      end
      MV_REQ: begin
        if (fl_req_ready) state_d = MV_WAIT;
      end
      MV_WAIT: begin
        if (fl_rsp_valid) begin
          buf_en  = 1'b1;
          state_d = MV_WRITE;
        end
      end
      MV_WRITE: begin
        if (mem_wr_ready) begin
          word_done = 1'b1;
          if (left_q == '0) begin
            run_done = 1'b1;
            state_d  = MV_IDLE;
          end else begin
            left_d  = left_q - CNT_W'(1);
            left_en = 1'b1;
            state_d = MV_REQ;
          end
        end
      end
      default: state_d = MV_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      left_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (left_en) left_q <= left_d;
      if (buf_en)  buf_q  <= fl_rsp_data;
    end
  end

  assign fl_req_valid = (state_q == MV_REQ);
  assign fl_req_addr  = src_ptr;
  assign fl_rsp_ready = (state_q == MV_WAIT);
  assign mem_wr_valid = (state_q == MV_WRITE);
  assign mem_wr_addr  = dst_ptr;
  assign mem_wr_data  = buf_q;
  assign run_active   = (state_q != MV_IDLE);
endmodule

// File: rtl/nordma_top.sv
module nordma_top
  import nordma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              fl_req_valid,
  input  logic              fl_req_ready,
  output logic [ADDR_W-1:0] fl_req_addr,
  input  logic              fl_rsp_valid,
  output logic              fl_rsp_ready,
  input  logic [DATA_W-1:0] fl_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              irq
);
  // Byte step per word; ADDR_W must not exceed REG_DW.
  localparam int STEP = DATA_W / 8;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              start, word_done, run_done, run_active;
  logic              stat_w, ien_w;
  logic [CNT_W-1:0]  start_cnt;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  nordma_regs #(.ADDR_W(ADDR_W), .STEP(STEP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .run_active (run_active),
    .word_done  (word_done),
    .run_done   (run_done),
    .start      (start),
    .start_cnt  (start_cnt),
    .src_ptr    (src_ptr),
    .dst_ptr    (dst_ptr),
    .stat_o     (stat_w),
    .ien_o      (ien_w),
    .irq        (irq)
  );

  nordma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start        (start),
    .start_cnt    (start_cnt),
    .src_ptr      (src_ptr),
    .dst_ptr      (dst_ptr),
    .fl_req_valid (fl_req_valid),
    .fl_req_ready (fl_req_ready),
    .fl_req_addr  (fl_req_addr),
    .fl_rsp_valid (fl_rsp_valid),
    .fl_rsp_ready (fl_rsp_ready),
    .fl_rsp_data  (fl_rsp_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .word_done    (word_done),
    .run_done     (run_done),
    .run_active   (run_active)
  );
endmodule

// File: rtl/nordma_checker.sv
module nordma_checker
  import nordma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              fl_req_valid,
  input logic              fl_req_ready,
  input logic [ADDR_W-1:0] fl_req_addr,
  input logic              fl_rsp_valid,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              busy,
  input logic              stat,
  input logic              irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_ready |=> fl_req_valid && $stable(fl_req_addr)); // R12

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R12

  AST_WR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_valid) |-> $past(fl_rsp_valid)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_req_valid && !mem_wr_valid); // R4

  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stat); // R6

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat); // R7

  AST_REVERSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_wr_en && (reg_addr == OFS_CTL) && reg_wdata[B_GO] && reg_wdata[B_DIR]
    |=> !busy); // R9
endmodule

bind nordma_top nordma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .fl_req_valid (fl_req_valid),
  .fl_req_ready (fl_req_ready),
  .fl_req_addr  (fl_req_addr),
  .fl_rsp_valid (fl_rsp_valid),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .busy         (run_active),
  .stat         (stat_w),
  .irq          (irq)
);

// File: tb/nordma_top_bench.sv
module nordma_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GO   = 32'h8000_0000;
  localparam logic [31:0] DIR  = 32'h2000_0000;
  localparam logic [31:0] IEN  = 32'h1000_0000;
  localparam logic [31:0] STAT = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        fl_req_valid, fl_req_ready, fl_rsp_valid, fl_rsp_ready;
  logic [31:0] fl_req_addr, fl_rsp_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int stall = 0;
  int nreq = 0;
  int nwr = 0;
  logic [31:0] exp_fl, exp_mem, exp_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  nordma_top u_nordma_top (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready), .fl_req_addr(fl_req_addr),
    .fl_rsp_valid(fl_rsp_valid), .fl_rsp_ready(fl_rsp_ready), .fl_rsp_data(fl_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .irq(irq)
  );

  function automatic logic [31:0] fdata(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flash and memory models, driven between edges
  initial begin : models
    int cyc = 0;
    bit pend = 0;
    bit rsp_taken = 0;
    logic [31:0] pend_addr = '0;
    fl_req_ready = 1'b0; fl_rsp_valid = 1'b0; fl_rsp_data = '0; mem_wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_taken) begin fl_rsp_valid = 1'b0; rsp_taken = 0; end
      if (pend && !fl_rsp_valid) begin
        fl_rsp_valid = 1'b1; fl_rsp_data = fdata(pend_addr); pend = 0;
      end
      if (fl_rsp_valid && fl_rsp_ready) rsp_taken = 1;
      fl_req_ready = (stall == 0) || (cyc % 2 == 1);
      if (fl_req_valid && fl_req_ready) begin
        check(fl_req_addr == exp_fl, "R3 flash read address", fl_req_addr, exp_fl);
        exp_fl = exp_fl + 4; pend = 1; pend_addr = fl_req_addr; nreq++;
      end
      mem_wr_ready = (stall == 0) || (cyc % 4 == 3);
      if (mem_wr_valid && mem_wr_ready) begin
        check(mem_wr_addr == exp_mem, "R3 memory write address", mem_wr_addr, exp_mem);
        check(mem_wr_data == fdata(exp_src), "R3 memory write data", mem_wr_data, fdata(exp_src));
        exp_mem = exp_mem + 4; exp_src = exp_src + 4; nwr++;
      end
    end
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start_run(input logic [31:0] fb, input logic [31:0] mb, input int cm1,
                           input logic [31:0] extra, input int st);
    logic [31:0] v;
    stall = st; exp_fl = fb; exp_mem = mb; exp_src = fb; nreq = 0; nwr = 0;
    reg_wr(6'h08, fb);
    reg_wr(6'h0C, mb);
    reg_wr(6'h20, GO | extra | (32'(cm1) << 2));
    reg_rd(6'h20, v);
    check(v[31] && v[30], "R4 go/busy after start", v, v | 32'hC000_0000);
  endtask

  task automatic finish_run(input logic [31:0] fb, input logic [31:0] mb, input int cm1);
    logic [31:0] v;
    int lingering = 0;
    bit done = 0;
    for (int i = 0; i < 120000 && !done; i++) begin
      @(negedge clk); #1;
      reg_rd(6'h20, v);
      if (!v[30]) done = 1;
      else if (nwr == cm1 + 1) lingering++;
    end
    check(nwr == cm1 + 1, "R3 write count", nwr, cm1 + 1);
    check(nreq == cm1 + 1, "R3 read count", nreq, cm1 + 1);
    check(lingering == 1, "R4 busy ends after last write", lingering, 1);
    check(v[31:30] == 2'b00, "R4 go/busy cleared", v, v & 32'h3FFF_FFFF);
    reg_rd(6'h08, v);
    check(v == fb + 32'(4 * (cm1 + 1)), "R5 source pointer advance", v, fb + 32'(4 * (cm1 + 1)));
    reg_rd(6'h0C, v);
    check(v == mb + 32'(4 * (cm1 + 1)), "R5 destination pointer advance", v, mb + 32'(4 * (cm1 + 1)));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(6'h08, v); check(v == 0, "R1 source pointer", v, 0);
    reg_rd(6'h0C, v); check(v == 0, "R1 destination pointer", v, 0);
    reg_rd(6'h20, v); check(v == 0, "R1 control word", v, 0);
    check(!irq && !fl_req_valid && !mem_wr_valid, "R1 outputs idle",
          {29'd0, irq, fl_req_valid, mem_wr_valid}, 0);
  endtask

  task automatic t_pointers();
    logic [31:0] v;
    reg_wr(6'h08, 32'h1234_5678);
    reg_wr(6'h0C, 32'h9ABC_DEF0);
    reg_rd(6'h08, v); check(v == 32'h1234_5678, "R2 source readback", v, 32'h1234_5678);
    reg_rd(6'h0C, v); check(v == 32'h9ABC_DEF0, "R2 destination readback", v, 32'h9ABC_DEF0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    reg_wr(6'h20, 32'h77FF_FFFF);
    reg_rd(6'h20, v);
    check(v == 32'h3700_FFFC, "R10 field readback", v, 32'h3700_FFFC);
    reg_wr(6'h20, STAT);
  endtask

  task automatic t_status_irq();
    logic [31:0] v;
    start_run(32'h0000_1000, 32'h8000_0000, 3, IEN, 0);
    finish_run(32'h0000_1000, 32'h8000_0000, 3);
    reg_rd(6'h20, v);
    check(v[27] && irq, "R6 status and irq at completion", {v[27], irq}, 2'b11);
    reg_wr(6'h20, IEN);
    reg_rd(6'h20, v);
    check(v[27] && irq, "R6 writing 0 keeps status", {v[27], irq}, 2'b11);
    reg_wr(6'h20, IEN | STAT);
    reg_rd(6'h20, v);
    check(!v[27] && !irq, "R6 write-one clears status", {v[27], irq}, 2'b00);
  endtask

  task automatic t_no_enable();
    logic [31:0] v;
    reg_wr(6'h20, STAT);
    start_run(32'h0000_2000, 32'h8000_2000, 2, 32'h0, 0);
    finish_run(32'h0000_2000, 32'h8000_2000, 2);
    reg_rd(6'h20, v);
    check(v[27] && !irq, "R7 status without irq", {v[27], irq}, 2'b10);
    reg_wr(6'h20, IEN);
    check(irq, "R7 late enable raises irq", irq, 1);
    reg_wr(6'h20, STAT);
    check(!irq, "R7 irq drops after clear", irq, 0);
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    start_run(32'h0000_3000, 32'h8000_3000, 5, 32'h0, 1);
    reg_wr(6'h08, 32'hDEAD_0000);
    reg_wr(6'h0C, 32'hBEEF_0000);
    reg_wr(6'h20, GO | IEN | 32'h0300_0000 | (32'h3FF << 2));
    reg_rd(6'h20, v);
    check(v[30] && v[28] && v[15:2] == 14'd5 && v[26:24] == 3'd0,
          "R8 only enable changes while busy", v, 32'hD000_0014);
    finish_run(32'h0000_3000, 32'h8000_3000, 5);
    check(irq, "R8 enable written while busy takes effect", irq, 1);
    reg_wr(6'h20, STAT);
  endtask

  task automatic t_reverse();
    logic [31:0] v;
    nreq = 0;
    reg_wr(6'h20, GO | DIR | (32'd2 << 2));
    repeat (10) @(negedge clk);
    reg_rd(6'h20, v);
    check(!v[30] && v[29], "R9 direction stored, no start", v, 32'h2000_0008);
    check(nreq == 0, "R9 no flash request", nreq, 0);
    reg_wr(6'h20, 32'h0);
  endtask

  task automatic t_min_max();
    start_run(32'h0000_4000, 32'h8000_4000, 0, 32'h0, 0);
    finish_run(32'h0000_4000, 32'h8000_4000, 0);   // R11 single word
    reg_wr(6'h20, STAT);
    start_run(32'h0010_0000, 32'h4000_0000, 16383, 32'h0, 0);
    finish_run(32'h0010_0000, 32'h4000_0000, 16383); // R11 full count
    reg_wr(6'h20, STAT);
  endtask

  task automatic t_stall();
    start_run(32'h0000_5004, 32'h8000_5008, 9, 32'h0, 1);
    finish_run(32'h0000_5004, 32'h8000_5008, 9);   // R12 under back-pressure
    reg_wr(6'h20, STAT);
    stall = 0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pointers();
    t_fields();
    t_status_irq();
    t_no_enable();
    t_busy_writes();
    t_reverse();
    t_stall();
    t_min_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule